// File: doc/BRIEF.md
# Streaming Window Pooling Unit

The unit sits behind a convolution stage and reduces one feature map, delivered as a raster-ordered stream of signed 8-bit values, before the values go back to memory. It keeps the most recent `LINES` image rows in on-chip row stores. Each accepted pixel, together with the values directly above it in those stores and the columns just before it, forms a square window of side `LINES+1` whose bottom-right corner is the new pixel. That window is reduced to its largest element or to its truncated mean, and the result is emitted only at positions that match the programmed step.

A pulse on `start` loads the configuration (mode, step, row width) and clears the column, row-fill and row-phase state so that a new map can begin. A bypass mode forwards every accepted pixel unchanged, for layers that have no pooling. Both stream edges use valid/ready handshakes. A single output register holds a result until the consumer takes it, and the input is held off meanwhile, so row stores are written only on real transfers.

The controller is a four-state machine. `ST_IDLE` is the state after reset, and no input is taken there. `start` moves from any state to `ST_BYPASS` when the mode is bypass and to `ST_FILL` otherwise. `ST_FILL` moves to `ST_RUN` when the last pixel of row `LINES-1` is accepted. `ST_RUN` and `ST_BYPASS` hold until the next `start`.

Top module: `pool_stream_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 0 until the first `start` pulse.
- R2: With `cfg_mode` 1x (bit 1 set) at `start`, every accepted input value appears on `out_data` unchanged, one output per input, in order, in the cycle after it is accepted.
- R3: With `cfg_mode` 00 at `start`, each output is the largest signed value of the (LINES+1)×(LINES+1) window ending at the just-accepted pixel.
- R4: With `cfg_mode` 01 at `start`, each output is the signed sum of the window divided by (LINES+1)², rounded toward zero.
- R5: No pooled output is produced before the pixel at row LINES, column LINES of the map (rows and columns counted from 0) has been accepted.
- R6: With `cfg_stride` 1 (step 2), outputs appear only for windows whose bottom-right row minus LINES and column minus LINES are both even.
- R7: With `cfg_stride` 0 (step 1), every window position fully inside the map produces one output.
- R8: `cfg_width` (1 to MAX_W) sets the row length; no window spans two rows, and no output appears for positions that do not fit.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` stays stable and `in_ready` is 0, and no value is lost.
- R10: A `start` pulse in the middle of a map discards the partial map, and the next map behaves as one that follows reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new map and load the configuration |
| cfg_mode | input | 2 | 00 maximum, 01 mean, 1x bypass |
| cfg_stride | input | 1 | 0 step 1, 1 step 2 |
| cfg_width | input | $clog2(MAX_W)+1 | Row length in pixels |
| in_valid | input | 1 | Input value offered |
| in_ready | output | 1 | Input value taken this cycle when valid |
| in_data | input | DW | Signed input value |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | DW | Signed result |

## Verification
Maps of several widths and heights are streamed with a pseudo-random pattern, a constant at the negative limit, a constant at the positive limit and a checkerboard of both extremes. The pseudo-random maps show whether the window covers the right rows and columns and whether outputs land on the step grid. The constant maps test the extremes of the maximum and of the mean divider. The checkerboard gives negative and positive non-integer means that separate truncation toward zero from flooring. Runs with gaps on the input and with a stalling consumer, a map only three pixels wide, and a map abandoned part way by a restart test the handshake, the edge handling and the reset of the counters.

// File: rtl/pool_pkg.sv
package pool_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_RUN    = 2'd2,
        ST_BYPASS = 2'd3
    } pool_state_e;

endpackage

// File: rtl/pool_line_store.sv
module pool_line_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/pool_window_reduce.sv
module pool_window_reduce #(
    parameter int DW   = 8,
    parameter int SIDE = 3,
    localparam int KK  = SIDE * SIDE
) (
    input  logic [KK*DW-1:0] win_flat,
    input  logic             avg_sel,
    output logic [DW-1:0]    result
);

    localparam int SW     = DW + $clog2(KK) + 1;
    localparam int DIV_SH = SW + $clog2(KK) + 1;
    localparam int PW     = SW + DIV_SH;
    localparam longint DIV_MUL = ((64'd1 << DIV_SH) + KK - 1) / KK;
    localparam logic [PW-1:0] MUL_C = PW'(DIV_MUL);

    logic [DW-1:0] v;
    logic [DW-1:0] best;
    logic [SW-1:0] acc;
    logic [SW-1:0] mag;
    logic [PW-1:0] prod;
    logic [DW-1:0] quo;
    logic [DW-1:0] avg;
    logic          neg;

    always_comb begin
        best = win_flat[DW-1:0];
        acc  = '0;
        v    = '0;
        for (int i = 0; i < KK; i++) begin
            v = win_flat[i*DW +: DW];
            if ($signed(v) > $signed(best)) begin
                best = v;
            end
            acc = acc + {{(SW-DW){v[DW-1]}}, v};
        end
        neg    = acc[SW-1];
        mag    = neg ? -acc : acc;
        prod   = {{DIV_SH{1'b0}}, mag} * MUL_C;
        quo    = DW'(prod >> DIV_SH);
        avg    = neg ? -quo : quo;
        result = avg_sel ? avg : best;
    end

endmodule

// File: rtl/pool_seq_ctrl.sv
module pool_seq_ctrl
    import pool_pkg::*;
#(
    parameter int LINES = 2,
    parameter int MAX_W = 256,
    localparam int AW   = $clog2(MAX_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_stride,
    input  logic [AW:0]   cfg_width,
    input  logic          in_fire,
    output pool_state_e   state,
    output logic [AW-1:0] col,
    output logic          lb_we,
    output logic          emit_pool,
    output logic          emit_pass,
    output logic          avg_sel
);

    localparam int   FW    = $clog2(LINES + 1);
    localparam logic L_ODD = (LINES % 2) == 1;

    pool_state_e   state_nx;
    logic [FW-1:0] fill_cnt;
    logic          vphase;
    logic          stride2_q;
    logic          avg_q;
    logic [AW:0]   width_m1_q;
    logic          last_col;
    logic          col_in_win;
    logic          step_ok;

    assign last_col   = ({1'b0, col} == width_m1_q);
    assign col_in_win = ({1'b0, col} >= (AW+1)'(LINES));
    assign step_ok    = !stride2_q || (!vphase && !(col[0] ^ L_ODD));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (start) begin
            state_nx = cfg_mode[1] ? ST_BYPASS : ST_FILL;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_IDLE;
                ST_FILL: begin
                    if (in_fire && last_col && (fill_cnt == FW'(LINES - 1))) begin
                        state_nx = ST_RUN;
                    end
                end
                ST_RUN:    state_nx = ST_RUN;
                ST_BYPASS: state_nx = ST_BYPASS;
            endcase
        end
    end

    // position counters and latched configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col        <= '0;
            fill_cnt   <= '0;
            vphase     <= 1'b0;
            stride2_q  <= 1'b0;
            avg_q      <= 1'b0;
            width_m1_q <= '0;
        end else if (start) begin
            col        <= '0;
            fill_cnt   <= '0;
            vphase     <= 1'b0;
            stride2_q  <= cfg_stride;
            avg_q      <= cfg_mode[0];
            width_m1_q <= cfg_width - 1'b1;
        end else if (in_fire) begin
            if (last_col) begin
                col <= '0;
                if (state == ST_FILL) begin
                    fill_cnt <= fill_cnt + 1'b1;
                end
                if (state == ST_RUN) begin
                    vphase <= ~vphase;
                end
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    // outputs per state
    always_comb begin
        lb_we     = 1'b0;
        emit_pool = 1'b0;
        emit_pass = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_FILL:   lb_we = in_fire;
            ST_RUN: begin
                lb_we     = in_fire;
                emit_pool = in_fire && col_in_win && step_ok;
            end
            ST_BYPASS: emit_pass = in_fire;
        endcase
    end

    assign avg_sel = avg_q;

endmodule

// File: rtl/pool_stream_unit.sv
module pool_stream_unit
    import pool_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LINES = 2,
    parameter int MAX_W = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [1:0]             cfg_mode,
    input  logic                   cfg_stride,
    input  logic [$clog2(MAX_W):0] cfg_width,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [DW-1:0]          in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [DW-1:0]          out_data
);

    localparam int AW   = $clog2(MAX_W);
    localparam int SIDE = LINES + 1;
    localparam int CW   = SIDE * DW;
    localparam int KK   = SIDE * SIDE;

    pool_state_e   fsm_state;
    logic [AW-1:0] col;
    logic          in_fire;
    logic          lb_we;
    logic          emit_pool;
    logic          emit_pass;
    logic          avg_sel;
    logic [DW-1:0] lb_rd [LINES];
    logic [CW-1:0] colv;
    logic [CW-1:0] hist [LINES];
    logic [KK*DW-1:0] win_flat;
    logic [DW-1:0] pooled;

    assign in_ready = (fsm_state != ST_IDLE) && !start && (!out_valid || out_ready);
    assign in_fire  = in_valid && in_ready;

    pool_seq_ctrl #(.LINES(LINES), .MAX_W(MAX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_mode   (cfg_mode),
        .cfg_stride (cfg_stride),
        .cfg_width  (cfg_width),
        .in_fire    (in_fire),
        .state      (fsm_state),
        .col        (col),
        .lb_we      (lb_we),
        .emit_pool  (emit_pool),
        .emit_pass  (emit_pass),
        .avg_sel    (avg_sel)
    );

    assign colv[DW-1:0] = in_data;

    for (genvar i = 0; i < LINES; i++) begin : g_row
        logic [DW-1:0] wd;
        if (i == 0) begin : g_first
            assign wd = in_data;
        end else begin : g_chain
            assign wd = lb_rd[i-1];
        end
        pool_line_store #(.DW(DW), .DEPTH(MAX_W)) u_store (
            .clk   (clk),
            .we    (lb_we),
            .addr  (col),
            .wdata (wd),
            .rdata (lb_rd[i])
        );
        assign colv[(i+1)*DW +: DW] = lb_rd[i];
        assign win_flat[(i+1)*CW +: CW] = hist[i];
    end

    assign win_flat[CW-1:0] = colv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < LINES; j++) begin
                hist[j] <= '0;
            end
        end else if (lb_we) begin
            hist[0] <= colv;
            for (int j = 1; j < LINES; j++) begin
                hist[j] <= hist[j-1];
            end
        end
    end

    pool_window_reduce #(.DW(DW), .SIDE(SIDE)) u_reduce (
        .win_flat (win_flat),
        .avg_sel  (avg_sel),
        .result   (pooled)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (emit_pool || emit_pass) begin
            out_valid <= 1'b1;
            out_data  <= emit_pass ? in_data : pooled;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/pool_checker.sv
module pool_checker
    import pool_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input pool_state_e   state,
    input logic          in_valid,
    input logic          in_ready,
    input logic [DW-1:0] in_data,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data
);

    a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    a_r9_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    a_r2_bypass_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BYPASS) && in_valid && in_ready |=> out_valid && (out_data == $past(in_data)));

    a_r5_fill_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) && in_valid && in_ready |=> !out_valid);

endmodule

bind pool_stream_unit pool_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (fsm_state),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/pool_stream_unit_test.sv
module pool_stream_unit_test;

    localparam int DW    = 8;
    localparam int LINES = 2;
    localparam int MAX_W = 256;
    localparam int SIDE  = LINES + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic       cfg_stride = 1'b0;
    logic [8:0] cfg_width = 9'd0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'd0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    pool_stream_unit #(.DW(DW), .LINES(LINES), .MAX_W(MAX_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_mode   (cfg_mode),
        .cfg_stride (cfg_stride),
        .cfg_width  (cfg_width),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data)
    );

    function automatic int pix(int pat, int seed, int r, int c);
        case (pat)
            1:       return -128;
            2:       return 127;
            3:       return ((r + c) % 2 == 1) ? 127 : -128;
            default: return ((seed * 73 + r * 29 + c * 53 + r * c * 7) % 256) - 128;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic run_frame(input int w, input int h, input int stride, input int mode,
                             input int pat, input int seed, input int bp, input int limit,
                             input string tag);
        int exp_q[$];
        int total;
        int idx;
        int cyc;
        bit first;
        total = (limit > 0) ? limit : w * h;
        if (mode >= 2) begin
            for (int p = 0; p < total; p++) exp_q.push_back(pix(pat, seed, p / w, p % w));
        end else if (limit == 0) begin
            for (int r = LINES; r < h; r++) begin
                for (int c = LINES; c < w; c++) begin
                    if (((r - LINES) % stride == 0) && ((c - LINES) % stride == 0)) begin
                        int mx;
                        int sm;
                        mx = -1000;
                        sm = 0;
                        for (int rr = r - LINES; rr <= r; rr++) begin
                            for (int cc = c - LINES; cc <= c; cc++) begin
                                int v;
                                v = pix(pat, seed, rr, cc);
                                sm += v;
                                if (v > mx) mx = v;
                            end
                        end
                        exp_q.push_back(mode == 1 ? sm / (SIDE * SIDE) : mx);
                    end
                end
            end
        end
        @(negedge clk);
        cfg_width  = 9'(w);
        cfg_stride = (stride == 2);
        cfg_mode   = 2'(mode);
        start      = 1'b1;
        in_valid   = 1'b0;
        out_ready  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        idx   = 0;
        cyc   = 0;
        first = 1'b1;
        while ((idx < total || exp_q.size() > 0 || out_valid) && cyc < 20000) begin
            in_valid  = (idx < total) && (bp == 0 || (cyc % 5) != 3);
            in_data   = in_valid ? 8'(pix(pat, seed, idx / w, idx % w)) : 8'd0;
            out_ready = (bp == 0) || ((cyc % 3) != 1);
            #1;
            if (out_valid && !out_ready) begin
                check(!in_ready, {tag, " R9 input held during stall"}, int'(in_ready), 0);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, {tag, " R8 unexpected output"}, $signed(out_data), 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check($signed(out_data) == e, tag, $signed(out_data), e);
                end
                if (first && mode < 2) begin
                    check(idx >= LINES * w + LINES + 1, {tag, " R5 early output"},
                          idx, LINES * w + LINES + 1);
                end
                first = 1'b0;
            end
            if (in_valid && in_ready) idx++;
            cyc++;
            @(negedge clk);
        end
        if (cyc >= 20000) check(1'b0, {tag, " stuck frame"}, idx, total);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        for (int k = 0; k < 6; k++) begin
            #1;
            check(!out_valid, {tag, " R8 no extra output"}, int'(out_valid), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
        check(!in_ready, "R1 in_ready after reset", int'(in_ready), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        in_valid = 1'b1;
        #1;
        check(!in_ready, "R1 idle refuses input", int'(in_ready), 0);
        check(!out_valid, "R1 idle no output", int'(out_valid), 0);
        in_valid = 1'b0;

        run_frame(7, 7, 2, 0, 0, 1, 0, 0, "R3 R6 max step2");
        run_frame(7, 7, 2, 1, 0, 2, 0, 0, "R4 R6 mean step2");
        run_frame(5, 6, 1, 1, 1, 0, 0, 0, "R4 R7 mean all-min");
        run_frame(6, 5, 1, 1, 3, 0, 0, 0, "R4 R7 mean checkerboard");
        run_frame(4, 4, 1, 0, 2, 0, 0, 0, "R3 R7 max all-max");
        run_frame(5, 3, 1, 2, 0, 3, 1, 0, "R2 R9 bypass stalled");
        run_frame(8, 6, 2, 0, 0, 4, 1, 0, "R9 R8 max step2 stalled");
        run_frame(5, 5, 1, 1, 0, 5, 0, 7, "R10 partial map");
        run_frame(6, 5, 2, 0, 0, 6, 0, 0, "R10 map after restart");
        run_frame(3, 3, 1, 1, 0, 7, 0, 0, "R8 R5 narrow map");
        run_frame(16, 4, 2, 0, 0, 8, 1, 0, "R8 R6 wide map");
        run_frame(9, 6, 1, 1, 0, 9, 1, 0, "R4 R7 mean stalled");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule